// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two tri-state data buses, called A and B, through a non-inverting transceiver that also has a storage register for each direction. The A-to-B register captures the A bus on a rising edge of its own clock. The B-to-A register captures the B bus on a rising edge of a second, independent clock. Capture does not depend on the enable, direction or select settings. It therefore continues while both buses are isolated, and a stored word can be replayed later even after the live bus has moved on.

An active-low output enable decides whether either bus is driven. When the enable is asserted, a direction input chooses the receiving bus. Each direction has a source select that picks either live data from the opposite bus or the word held in that direction's register. At most one bus is driven at any time. A bus that the block does not drive is released to high impedance on its inout port. A synchronous active-high reset clears both registers on their own clock edges.

Top module: `reg_bus_xcvr`

## Requirements
- R1: A reset applied across a rising edge of each capture clock clears both registers to zero. Zero then appears on whichever bus drives stored data.
- R2: On each rising edge of `clk_ab` while `rst` is low, the A-to-B register loads the value present on `bus_a`.
- R3: On each rising edge of `clk_ba` while `rst` is low, the B-to-A register loads the value present on `bus_b`.
- R4: While `oe_n` is 1, the block drives neither bus, so both read all-Z when nothing else drives them.
- R5: With `oe_n`=0 and `dir`=1, the block drives `bus_b` and leaves `bus_a` undriven.
- R6: With `oe_n`=0 and `dir`=0, the block drives `bus_a` and leaves `bus_b` undriven.
- R7: With `oe_n`=0, `dir`=1 and `sel_ab`=0, `bus_b` equals the live `bus_a` value, bit for bit and without inversion.
- R8: With `oe_n`=0, `dir`=1 and `sel_ab`=1, `bus_b` equals the A-to-B register contents.
- R9: With `oe_n`=0, `dir`=0 and `sel_ba`=0, `bus_a` equals the live `bus_b` value, bit for bit and without inversion.
- R10: With `oe_n`=0, `dir`=0 and `sel_ba`=1, `bus_a` equals the B-to-A register contents.
- R11: Words captured while `oe_n`=1 are held until the next capture edge and are replayed unchanged after the live buses change.
- R12: A bus that the block is driving can itself be captured. With `dir`=0 and `sel_ba`=0, a `clk_ab` edge stores the value that the block passes onto `bus_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register, rising edge |
| clk_ba | input | 1 | Capture clock of the B-to-A register, rising edge |
| rst | input | 1 | Synchronous active-high clear of both registers |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B word |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A word |
| bus_a | inout | WIDTH | Bus A data |
| bus_b | inout | WIDTH | Bus B data |

## Verification
The assertions assume that no external agent drives a bus while the block is driving it, because any contention would read as X. They also assume that a bus is held at known levels whenever its capture clock rises, and that control and data inputs stay still around capture edges. The bench meets these assumptions as follows. Each scenario releases the receiving bus before it enables the block's driver. Every capture is taken with the source bus actively driven. All inputs change only between clock pulses, and outputs are sampled after they have settled.

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  inout  wire  [WIDTH-1:0] bus_a,
  inout  wire  [WIDTH-1:0] bus_b
);

  logic [WIDTH-1:0] q_ab;
  logic [WIDTH-1:0] q_ba;
  logic             drv_a;
  logic             drv_b;
  logic [WIDTH-1:0] to_a;
  logic [WIDTH-1:0] to_b;

  always_ff @(posedge clk_ab) begin
    if (rst) q_ab <= '0;
    else     q_ab <= bus_a;
  end

  always_ff @(posedge clk_ba) begin
    if (rst) q_ba <= '0;
    else     q_ba <= bus_b;
  end

  assign drv_b = !oe_n &&  dir;
  assign drv_a = !oe_n && !dir;

  assign to_b = sel_ab ? q_ab : bus_a;
  assign to_a = sel_ba ? q_ba : bus_b;

  assign bus_b = drv_b ? to_b : {WIDTH{1'bz}};
  assign bus_a = drv_a ? to_a : {WIDTH{1'bz}};

endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             rst,
  input logic             oe_n,
  input logic             dir,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] bus_a,
  input logic [WIDTH-1:0] bus_b,
  input logic [WIDTH-1:0] q_ab,
  input logic [WIDTH-1:0] q_ba
);

  AST_CAPTURE_AB: assert property (@(posedge clk_ab) disable iff (rst) !$past(rst) |-> q_ab == $past(bus_a)); // R2
  AST_CAPTURE_BA: assert property (@(posedge clk_ba) disable iff (rst) !$past(rst) |-> q_ba == $past(bus_b)); // R3
  AST_LIVE_TO_B: assert property (@(posedge clk_ab) disable iff (rst) (!oe_n && dir && !sel_ab) |-> bus_b == bus_a); // R7
  AST_STORED_TO_B: assert property (@(posedge clk_ab) disable iff (rst) (!oe_n && dir && sel_ab) |-> bus_b == q_ab); // R8
  AST_LIVE_TO_A: assert property (@(posedge clk_ba) disable iff (rst) (!oe_n && !dir && !sel_ba) |-> bus_a == bus_b); // R9
  AST_STORED_TO_A: assert property (@(posedge clk_ba) disable iff (rst) (!oe_n && !dir && sel_ba) |-> bus_a == q_ba); // R10

endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .bus_a(bus_a), .bus_b(bus_b),
  .q_ab(q_ab), .q_ba(q_ba)
);

// File: tb/test_reg_bus_xcvr.sv
module test_reg_bus_xcvr;
  localparam int W = 8;

  logic clk = 0;
  logic clk_ab = 0, clk_ba = 0, rst = 1;
  logic oe_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_val = '0, b_val = '0;
  logic a_en = 0, b_en = 0;
  wire  [W-1:0] bus_a, bus_b;
  int total = 0, bad = 0;

  assign bus_a = a_en ? a_val : {W{1'bz}};
  assign bus_b = b_en ? b_val : {W{1'bz}};

  always #4 clk = ~clk;

  reg_bus_xcvr #(.WIDTH(W)) i_reg_bus_xcvr (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .bus_a(bus_a), .bus_b(bus_b)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic pulse(input bit ab, input bit ba);
    @(negedge clk);
    clk_ab = ab; clk_ba = ba;
    @(posedge clk);
    clk_ab = 0; clk_ba = 0;
    #2;
  endtask

  task automatic t_reset();
    a_en = 1; b_en = 1; a_val = 8'h5A; b_val = 8'hA5; rst = 1;
    pulse(1, 1);
    rst = 0;
    b_en = 0; oe_n = 0; dir = 1; sel_ab = 1; settle();
    chk("R1 stored A-to-B after reset", bus_b, 8'h00);
    b_en = 1; a_en = 0; dir = 0; sel_ba = 1; settle();
    chk("R1 stored B-to-A after reset", bus_a, 8'h00);
  endtask

  task automatic t_isolate();
    oe_n = 1; a_en = 0; b_en = 0; settle();
    chk("R4 bus_a floats", bus_a, {W{1'bz}});
    chk("R4 bus_b floats", bus_b, {W{1'bz}});
  endtask

  task automatic t_park_replay();
    oe_n = 1; a_en = 1; b_en = 1; a_val = 8'h3C; b_val = 8'hC3; settle();
    chk("R4 isolated A keeps external value", bus_a, 8'h3C);
    chk("R4 isolated B keeps external value", bus_b, 8'hC3);
    pulse(1, 1);
    a_val = 8'h11; b_val = 8'h22;
    b_en = 0; oe_n = 0; dir = 1; sel_ab = 1; settle();
    chk("R8 R11 R2 replay stored A word", bus_b, 8'h3C);
    chk("R5 A left to external driver", bus_a, 8'h11);
    sel_ab = 0; settle();
    chk("R7 live A to B", bus_b, 8'h11);
    a_val = 8'h80; settle();
    chk("R7 live A tracks change", bus_b, 8'h80);
    a_en = 0; settle();
    chk("R5 A undriven by block", bus_a, {W{1'bz}});
    b_en = 1; b_val = 8'h22; dir = 0; sel_ba = 1; settle();
    chk("R10 R11 R3 replay stored B word", bus_a, 8'hC3);
    sel_ba = 0; settle();
    chk("R9 live B to A", bus_a, 8'h22);
    b_val = 8'h01; settle();
    chk("R9 live B tracks change", bus_a, 8'h01);
    chk("R6 B left to external driver", bus_b, 8'h01);
    b_en = 0; settle();
    chk("R6 B undriven by block", bus_b, {W{1'bz}});
  endtask

  task automatic t_capture_driven();
    oe_n = 0; dir = 0; sel_ba = 0; a_en = 0; b_en = 1; b_val = 8'h77; settle();
    pulse(1, 0);
    b_val = 8'h0F;
    pulse(0, 1);
    b_en = 0; a_en = 1; a_val = 8'h00; dir = 1; sel_ab = 1; settle();
    chk("R12 driven A bus captured", bus_b, 8'h77);
    a_en = 0; b_en = 1; b_val = 8'hFF; dir = 0; sel_ba = 1; settle();
    chk("R3 B word after second capture", bus_a, 8'h0F);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    settle();
    t_reset();
    t_isolate();
    t_park_replay();
    t_capture_driven();
    t_isolate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule